// File: doc/BRIEF.md
# Instruction exception classifier

This block sits at the decode/execute boundary of a small in-order processor. Each issued instruction arrives with pre-decoded class flags. The block decides which exception category, if any, the instruction raises. The same instruction can get a different verdict depending on where it sits. An instruction in the slot that follows a delayed branch may not change the program counter, may not be a 32-bit encoding, may not restore the register bank and may not divide. Any of those there, or any undefined code, is a slot fault. Outside a delay slot, undefined code is a general fault and the other classes are legal.

The block also checks the operands of both integer divides. A zero divisor faults, and so does the signed quotient that overflows. It passes on any floating-point fault that the execute stage reports. When the floating-point unit is in standby, every floating-point instruction is treated as undefined code. The winning cause is registered and shown for one cycle with a valid pulse. Opcode decoding, vector fetch and context saving belong to other blocks.

Top module: `instr_exc_classifier`

## Requirements
- R1: An issued trap instruction that is outside a delay slot and not undefined gives cause code 3 (trap).
- R2: Undefined code issued outside a delay slot gives cause code 2 (general illegal).
- R3: Undefined code issued in a delay slot gives cause code 1 (slot illegal).
- R4: While `fpu_standby` is 1, an instruction flagged `is_fpu_op` counts as undefined code. While it is 0, the same instruction raises nothing by itself.
- R5: In a delay slot, these instructions give cause 1: a delayed branch, any other PC-writing instruction, a trap, a 32-bit instruction, a bank restore, and either divide. Outside a slot, PC-writing, 32-bit and bank-restore instructions raise nothing.
- R6: An unsigned or signed divide with a divisor of zero gives cause code 4 (divide error).
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives cause code 4. The same operands in an unsigned divide raise nothing, and so do other signed operands with a nonzero divisor.
- R8: An issued instruction with `fpu_fault` set gives cause code 5 (FPU exception).
- R9: `in_slot` becomes 1 after a valid delayed branch that raises nothing. It returns to 0 after the next valid instruction. It holds while `issue_valid` is 0, and it is 0 after reset and after any exception.
- R10: When several causes hold, only one is reported, in this order from highest: slot illegal (1), general illegal (2), trap (3), divide error (4), FPU (5).
- R11: The cause appears on `exc_cause` one clock after issue, with `exc_valid` high for that single cycle. `exc_cause` is 0 and `exc_valid` is 0 when there is no exception or `issue_valid` was 0. After reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| is_trap | input | 1 | Trap instruction |
| is_undef | input | 1 | Undefined opcode |
| is_fpu_op | input | 1 | Floating-point or FPU-related CPU instruction |
| fpu_standby | input | 1 | FPU is in standby |
| is_delayed_br | input | 1 | Branch with a delay slot |
| is_pc_write | input | 1 | Other instruction that rewrites the PC |
| is_wide | input | 1 | 32-bit-encoded instruction |
| is_bank_restore | input | 1 | Register-bank restore instruction |
| is_div_u | input | 1 | Unsigned divide |
| is_div_s | input | 1 | Signed divide |
| dividend | input | XLEN | Divide numerator |
| divisor | input | XLEN | Divide denominator |
| fpu_fault | input | 1 | Execute stage reports an FPU exception flag |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 3 | Cause code (0 none, 1 slot, 2 general, 3 trap, 4 divide, 5 FPU) |
| in_slot | output | 1 | Next instruction sits in a delay slot |

## Verification
The hardest state to reach is a delay slot with a given instruction in it. The slot exists only after a clean delayed branch and disappears after the very next valid instruction or any exception. The stimulus table is ordered so that a delayed branch comes right before each instruction under test. The same instructions then appear again without the branch to show they are legal elsewhere. Idle cycles inside a slot, a delayed branch that carries an FPU fault, and a reset taken while inside a slot are driven as directed cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_SLOT = 3'd1,
    CAUSE_GEN  = 3'd2,
    CAUSE_TRAP = 3'd3,
    CAUSE_DIV  = 3'd4,
    CAUSE_FPU  = 3'd5
  } cause_e;

  // number of request lines, index 0 has highest priority
  localparam int NREQ = 5;
endpackage

// File: rtl/exc_slot_track.sv
module exc_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  input  logic is_delayed_br,
  input  logic exc_take,
  output logic slot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slot_q <= 1'b0;
    else if (exc_take)    slot_q <= 1'b0;
    else if (issue_valid) slot_q <= is_delayed_br;
  end
endmodule

// File: rtl/exc_div_check.sv
module exc_div_check #(
  parameter int XLEN = 32
) (
  input  logic            is_div_u,
  input  logic            is_div_s,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            div_hit
);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] MINUS_ONE = {XLEN{1'b1}};

  function automatic logic zero_den(input logic [XLEN-1:0] d);
    return d == '0;
  endfunction

  function automatic logic signed_ovf(input logic [XLEN-1:0] n,
                                      input logic [XLEN-1:0] d);
    return (n == MOST_NEG) && (d == MINUS_ONE);
  endfunction

  always_comb begin
    div_hit = ((is_div_u | is_div_s) & zero_den(divisor))
            | (is_div_s & signed_ovf(dividend, divisor));
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic [NREQ-1:0] req,
  output cause_e          cause,
  output logic            any
);
  always_comb begin
    cause = CAUSE_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) cause = cause_e'(3'(i + 1));
    end
    any = |req;
  end
endmodule

// File: rtl/instr_exc_classifier.sv
module instr_exc_classifier
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic            is_trap,
  input  logic            is_undef,
  input  logic            is_fpu_op,
  input  logic            fpu_standby,
  input  logic            is_delayed_br,
  input  logic            is_pc_write,
  input  logic            is_wide,
  input  logic            is_bank_restore,
  input  logic            is_div_u,
  input  logic            is_div_s,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic            fpu_fault,
  output logic            exc_valid,
  output logic [2:0]      exc_cause,
  output logic            in_slot
);
  logic            slot_q;
  logic            undef_eff;
  logic            slot_forbid;
  logic            slot_bad;
  logic            gen_bad;
  logic            div_hit;
  logic [NREQ-1:0] req;
  cause_e          nxt_cause;
  logic            exc_take;
  logic            valid_q;
  cause_e          cause_q;

  // standby turns every floating-point class into undefined code
  assign undef_eff   = is_undef | (is_fpu_op & fpu_standby);
  assign slot_forbid = is_delayed_br | is_pc_write | is_trap | is_wide
                     | is_bank_restore | is_div_u | is_div_s;
  assign slot_bad    = slot_q & (undef_eff | slot_forbid);
  assign gen_bad     = ~slot_q & undef_eff;

  exc_div_check #(.XLEN(XLEN)) u_div (
    .is_div_u (is_div_u),
    .is_div_s (is_div_s),
    .dividend (dividend),
    .divisor  (divisor),
    .div_hit  (div_hit)
  );

  assign req = issue_valid ? {fpu_fault, div_hit, is_trap, gen_bad, slot_bad}
                           : '0;

  exc_prio u_prio (
    .req   (req),
    .cause (nxt_cause),
    .any   (exc_take)
  );

  exc_slot_track u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .is_delayed_br (is_delayed_br),
    .exc_take      (exc_take),
    .slot_q        (slot_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      valid_q <= exc_take;
      cause_q <= nxt_cause;
    end
  end

  assign exc_valid = valid_q;
  assign exc_cause = cause_q;
  assign in_slot   = slot_q;
endmodule

// File: rtl/exc_classifier_chk.sv
module exc_classifier_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic            is_trap,
  input logic            is_delayed_br,
  input logic            is_div_u,
  input logic            is_div_s,
  input logic [XLEN-1:0] divisor,
  input logic            undef_eff,
  input logic            exc_valid,
  input logic [2:0]      exc_cause,
  input logic            in_slot
);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !exc_valid);

  a_r11_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid == (exc_cause != 3'd0));

  a_r9_clear_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !in_slot);

  a_r9_set_by_branch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_slot) |-> $past(issue_valid && is_delayed_br));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(in_slot));

  a_r1_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && is_trap && !in_slot && !undef_eff) |=> exc_cause == 3'd3);

  a_r3_slot_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && in_slot && undef_eff) |=> exc_cause == 3'd1);

  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !in_slot && !undef_eff && !is_trap
     && (is_div_u || is_div_s) && divisor == '0) |=> exc_cause == 3'd4);
endmodule

bind instr_exc_classifier exc_classifier_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_valid   (issue_valid),
  .is_trap       (is_trap),
  .is_delayed_br (is_delayed_br),
  .is_div_u      (is_div_u),
  .is_div_s      (is_div_s),
  .divisor       (divisor),
  .undef_eff     (undef_eff),
  .exc_valid     (exc_valid),
  .exc_cause     (exc_cause),
  .in_slot       (in_slot)
);

// File: tb/instr_exc_classifier_test.sv
module instr_exc_classifier_test;
  localparam int XLEN = 32;
  localparam int NVEC = 43;
  // flags order: valid trap undef fpu stby dbr pcw wide bank divu divs ffault
  localparam logic [79:0] VEC [NVEC] = '{
    {12'b1100_0000_0000, 32'h0, 32'h1, 3'd3, 1'b0}, // R1 trap
    {12'b1010_0000_0000, 32'h0, 32'h1, 3'd2, 1'b0}, // R2 undef
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1}, // R9 branch
    {12'b1010_0000_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R3 undef in slot
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0000_0000, 32'h0, 32'h1, 3'd0, 1'b0}, // R9 clears
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b0100_0000_0000, 32'h0, 32'h1, 3'd0, 1'b1}, // R11 idle, R9 hold
    {12'b1000_0010_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R5 pc write in slot
    {12'b1000_0010_0000, 32'h0, 32'h1, 3'd0, 1'b0}, // R5 pc write outside
    {12'b1000_0001_0000, 32'h0, 32'h1, 3'd0, 1'b0}, // R5 wide outside
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0001_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R5 wide in slot
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0000_1000, 32'h0, 32'h1, 3'd1, 1'b0}, // R5 bank in slot
    {12'b1000_0000_1000, 32'h0, 32'h1, 3'd0, 1'b0}, // R5 bank outside
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0000_0100, 32'h9, 32'h5, 3'd1, 1'b0}, // R5 divide in slot
    {12'b1000_0000_0100, 32'h9, 32'h0, 3'd4, 1'b0}, // R6 unsigned /0
    {12'b1000_0000_0010, 32'h7, 32'h0, 3'd4, 1'b0}, // R6 signed /0
    {12'b1000_0000_0010, 32'h80000000, 32'hFFFFFFFF, 3'd4, 1'b0}, // R7
    {12'b1000_0000_0100, 32'h80000000, 32'hFFFFFFFF, 3'd0, 1'b0}, // R7 unsigned
    {12'b1000_0000_0010, 32'h80000000, 32'h00000001, 3'd0, 1'b0}, // R7
    {12'b1000_0000_0010, 32'h7FFFFFFF, 32'hFFFFFFFF, 3'd0, 1'b0}, // R7
    {12'b1001_1000_0000, 32'h0, 32'h1, 3'd2, 1'b0}, // R4 standby
    {12'b1001_0000_0000, 32'h0, 32'h1, 3'd0, 1'b0}, // R4 active
    {12'b1000_0000_0001, 32'h0, 32'h1, 3'd5, 1'b0}, // R8 fault
    {12'b1001_0000_0001, 32'h0, 32'h1, 3'd5, 1'b0}, // R8 fpu op fault
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1001_1000_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R4 standby in slot
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1100_0000_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R5 trap in slot
    {12'b1110_0000_0000, 32'h0, 32'h1, 3'd2, 1'b0}, // R10 general>trap
    {12'b1100_0000_0100, 32'h3, 32'h0, 3'd3, 1'b0}, // R10 trap>div
    {12'b1000_0000_0011, 32'h3, 32'h0, 3'd4, 1'b0}, // R10 div>fpu
    {12'b1000_0110_0001, 32'h0, 32'h1, 3'd5, 1'b0}, // R9 exc clears slot
    {12'b1000_0000_0000, 32'h0, 32'h1, 3'd0, 1'b0},
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0000_0100, 32'h3, 32'h0, 3'd1, 1'b0}, // R10 slot>div
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd1, 1'b0}, // R5 branch in slot
    {12'b1000_0110_0000, 32'h0, 32'h1, 3'd0, 1'b1},
    {12'b0000_0000_0000, 32'h0, 32'h1, 3'd0, 1'b1}  // R11 no pulse
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 0, is_trap = 0, is_undef = 0, is_fpu_op = 0;
  logic fpu_standby = 0, is_delayed_br = 0, is_pc_write = 0, is_wide = 0;
  logic is_bank_restore = 0, is_div_u = 0, is_div_s = 0, fpu_fault = 0;
  logic [XLEN-1:0] dividend = '0, divisor = '0;
  logic       exc_valid;
  logic [2:0] exc_cause;
  logic       in_slot;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  instr_exc_classifier #(.XLEN(XLEN)) uut (.*);

  task automatic check(input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] f, input logic [31:0] a,
                       input logic [31:0] b);
    {issue_valid, is_trap, is_undef, is_fpu_op, fpu_standby, is_delayed_br,
     is_pc_write, is_wide, is_bank_restore, is_div_u, is_div_s, fpu_fault} = f;
    dividend = a;
    divisor  = b;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset valid", {3'b0, exc_valid}, 4'd0);
    check("R11 reset cause", {1'b0, exc_cause}, 4'd0);
    check("R9 reset slot", {3'b0, in_slot}, 4'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][79:68], VEC[i][67:36], VEC[i][35:4]);
      @(posedge clk); #1;
      check($sformatf("R1-vector %0d cause", i), {1'b0, exc_cause},
            {1'b0, VEC[i][3:1]});
      check($sformatf("R11 vector %0d valid", i), {3'b0, exc_valid},
            {3'b0, VEC[i][3:1] != 3'd0});
      check($sformatf("R9 vector %0d slot", i), {3'b0, in_slot},
            {3'b0, VEC[i][0]});
    end

    // R11: pulse lasts one cycle
    drive(12'b1100_0000_0000, 32'h0, 32'h1);
    @(posedge clk); #1;
    drive(12'b0000_0000_0000, 32'h0, 32'h1);
    check("R11 pulse", {3'b0, exc_valid}, 4'd1);
    @(posedge clk); #1;
    check("R11 pulse drops", {3'b0, exc_valid}, 4'd0);
    check("R11 cause drops", {1'b0, exc_cause}, 4'd0);

    // R9: reset while in a slot clears the slot
    drive(12'b1000_0110_0000, 32'h0, 32'h1);
    @(posedge clk); #1;
    drive(12'b0000_0000_0000, 32'h0, 32'h1);
    check("R9 slot before reset", {3'b0, in_slot}, 4'd1);
    rst_n = 1'b0;
    #2;
    check("R9 slot after reset", {3'b0, in_slot}, 4'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    drive(12'b1010_0000_0000, 32'h0, 32'h1);
    @(posedge clk); #1;
    check("R2 undef after reset", {1'b0, exc_cause}, 4'd2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule